// File: doc/BRIEF.md
# Banked Multi-Port Activation Memory

This block holds the input and output tensors of a convolution accelerator. In every cycle it serves three read requesters and two write requesters without holding any of them back. Read port 0 and read port 1 carry the compute array's two operand streams, and read port 2 carries the spill engine. Write port 0 takes the array's results and write port 1 takes the restore engine. This allows an elementwise operation to fetch two source tensors while a third tensor is stored, and lets tensors move to and from external memory at the same time.

The storage is made of `BANKS` banks. Each bank is a simple dual-port RAM with one read port and one write port. The upper address bits pick the bank, and a crossbar routes each request to the bank that owns its address. Each word holds `LANES` elements of `ELEM_W` bits. Concurrent requests are conflict-free only when the tensor allocator has placed each concurrent stream in a different bank. The block does not arbitrate. When two reads or two writes meet in the same bank, it serves the lower-numbered port, drops the other request and raises a sticky error flag.

Top module: `actmem_top`

## Requirements
- R1: When the three reads target three different banks and the two writes target two different banks, all five requests are served in the same cycle and none is delayed.
- R2: The bank index is address bits [AW-1:log2(BANK_DEPTH)] and the word offset is the lower bits, so each bank owns a contiguous range. With BANK_DEPTH=64, address 63 is in bank 0 and address 64 is in bank 1, and reads to these two addresses do not conflict.
- R3: An accepted read returns its data with `rd_valid_o` high on the same port exactly one cycle later. `rd_data_o` of a port is all zero whenever its valid is low.
- R4: A read and a write to the same address in the same cycle return the old word. A read in a later cycle returns the new word.
- R5: When two or more in-range reads target the same bank in one cycle, only the lowest-numbered of those ports is served. The others get no valid in the next cycle, and a collision is recorded.
- R6: When both in-range writes target the same bank in one cycle, only write port 0 is stored. The word at write port 1's address keeps its old value, and a collision is recorded.
- R7: `collision_o` goes high in the cycle after a collision and stays high until reset. It stays low as long as no collision has occurred.
- R8: An address at or above BANKS*BANK_DEPTH is out of range. A read to it gives no valid, a write to it changes nothing, and it never counts toward a collision.
- R9: While reset is asserted and right after it, every `rd_valid_o` bit and `collision_o` are low. Reset does not clear the stored words.
- R10: Element i of a word sits at bits [i*ELEM_W +: ELEM_W]. A word is stored and returned whole, with all lanes intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 3 | Read request per read port |
| rd_addr_i | input | 3 x AW | Word address per read port |
| rd_valid_o | output | 3 | Read data valid per port, one cycle after request |
| rd_data_o | output | 3 x ELEM_W*LANES | Read data per port |
| wr_en_i | input | 2 | Write request per write port |
| wr_addr_i | input | 2 x AW | Word address per write port |
| wr_data_i | input | 2 x ELEM_W*LANES | Write data per write port |
| collision_o | output | 1 | Sticky flag for a same-bank read or write conflict |

## Verification
The bench builds the block with three banks of 64 words and eight 8-bit lanes. This gives an 8-bit address space in which addresses 192 to 255 are out of range, so random traffic hits bank edges, out-of-range requests and same-bank collisions often. The small depth lets the whole array be filled before traffic starts. After that, every read result can be predicted exactly, including read-before-write overlaps and dropped writes.

// File: rtl/actmem_pkg.sv
package actmem_pkg;
  localparam int unsigned N_RD = 3;  // operand A, operand B, spill
  localparam int unsigned N_WR = 2;  // array result, restore
endpackage

// File: rtl/actmem_bank.sv
module actmem_bank #(
  parameter  int unsigned DW    = 64,
  parameter  int unsigned DEPTH = 1024,
  localparam int unsigned OW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [OW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [OW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // read samples the array before this edge's write lands
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/actmem_xbar.sv
module actmem_xbar import actmem_pkg::*; #(
  parameter  int unsigned BANKS      = 3,
  parameter  int unsigned BANK_DEPTH = 1024,
  parameter  int unsigned DW         = 64,
  localparam int unsigned OW         = $clog2(BANK_DEPTH),
  localparam int unsigned AW         = $clog2(BANKS*BANK_DEPTH),
  localparam int unsigned BW         = AW - OW
) (
  input  logic [N_RD-1:0]         rd_en_i,
  input  logic [N_RD-1:0][AW-1:0] rd_addr_i,
  input  logic [N_WR-1:0]         wr_en_i,
  input  logic [N_WR-1:0][AW-1:0] wr_addr_i,
  input  logic [N_WR-1:0][DW-1:0] wr_data_i,
  output logic [BANKS-1:0]        b_re_o,
  output logic [OW-1:0]           b_raddr_o [BANKS],
  output logic [BANKS-1:0]        b_we_o,
  output logic [OW-1:0]           b_waddr_o [BANKS],
  output logic [DW-1:0]           b_wdata_o [BANKS],
  output logic [N_RD-1:0]         rd_gnt_o,
  output logic [N_RD-1:0][BW-1:0] rd_bank_o,
  output logic                    coll_o
);
  localparam logic [AW:0] LIMIT = (AW+1)'(BANKS*BANK_DEPTH);

  function automatic logic in_range(input logic [AW-1:0] a);
    return {1'b0, a} < LIMIT;
  endfunction

  logic rd_coll, wr_coll;
  logic [BW-1:0] wbank [N_WR];

  // lowest port wins a bank; later ports to the same bank are dropped
  always_comb begin
    b_re_o   = '0;
    rd_gnt_o = '0;
    rd_coll  = 1'b0;
    for (int b = 0; b < BANKS; b++) b_raddr_o[b] = '0;
    for (int p = 0; p < N_RD; p++) begin
      rd_bank_o[p] = rd_addr_i[p][AW-1:OW];
      if (rd_en_i[p] && in_range(rd_addr_i[p])) begin
        if (b_re_o[rd_bank_o[p]]) begin
          rd_coll = 1'b1;
        end else begin
          b_re_o[rd_bank_o[p]]    = 1'b1;
          b_raddr_o[rd_bank_o[p]] = rd_addr_i[p][OW-1:0];
          rd_gnt_o[p]             = 1'b1;
        end
      end
    end
  end

  always_comb begin
    b_we_o  = '0;
    wr_coll = 1'b0;
    for (int b = 0; b < BANKS; b++) begin
      b_waddr_o[b] = '0;
      b_wdata_o[b] = '0;
    end
    for (int w = 0; w < N_WR; w++) begin
      wbank[w] = wr_addr_i[w][AW-1:OW];
      if (wr_en_i[w] && in_range(wr_addr_i[w])) begin
        if (b_we_o[wbank[w]]) begin
          wr_coll = 1'b1;
        end else begin
          b_we_o[wbank[w]]    = 1'b1;
          b_waddr_o[wbank[w]] = wr_addr_i[w][OW-1:0];
          b_wdata_o[wbank[w]] = wr_data_i[w];
        end
      end
    end
  end

  assign coll_o = rd_coll | wr_coll;
endmodule

// File: rtl/actmem_rdret.sv
module actmem_rdret import actmem_pkg::*; #(
  parameter int unsigned BANKS = 3,
  parameter int unsigned DW    = 64,
  parameter int unsigned BW    = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_RD-1:0]         rd_gnt_i,
  input  logic [N_RD-1:0][BW-1:0] rd_bank_i,
  input  logic [DW-1:0]           bank_rdata_i [BANKS],
  output logic [N_RD-1:0]         rd_valid_o,
  output logic [N_RD-1:0][DW-1:0] rd_data_o
);
  logic [N_RD-1:0]         vld_q;
  logic [N_RD-1:0][BW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      sel_q <= '0;
    end else begin
      vld_q <= rd_gnt_i;
      sel_q <= rd_bank_i;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_ret
    assign rd_data_o[p] = vld_q[p] ? bank_rdata_i[sel_q[p]] : '0;
  end

  assign rd_valid_o = vld_q;
endmodule

// File: rtl/actmem_top.sv
module actmem_top import actmem_pkg::*; #(
  parameter  int unsigned ELEM_W     = 8,
  parameter  int unsigned LANES      = 8,
  parameter  int unsigned BANKS      = 3,
  parameter  int unsigned BANK_DEPTH = 256,
  localparam int unsigned DW         = ELEM_W * LANES,
  localparam int unsigned OW         = $clog2(BANK_DEPTH),
  localparam int unsigned AW         = $clog2(BANKS*BANK_DEPTH),
  localparam int unsigned BW         = AW - OW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_RD-1:0]         rd_en_i,
  input  logic [N_RD-1:0][AW-1:0] rd_addr_i,
  output logic [N_RD-1:0]         rd_valid_o,
  output logic [N_RD-1:0][DW-1:0] rd_data_o,
  input  logic [N_WR-1:0]         wr_en_i,
  input  logic [N_WR-1:0][AW-1:0] wr_addr_i,
  input  logic [N_WR-1:0][DW-1:0] wr_data_i,
  output logic                    collision_o
);
  logic [BANKS-1:0]        b_re, b_we;
  logic [OW-1:0]           b_raddr [BANKS];
  logic [OW-1:0]           b_waddr [BANKS];
  logic [DW-1:0]           b_wdata [BANKS];
  logic [DW-1:0]           b_rdata [BANKS];
  logic [N_RD-1:0]         rd_gnt;
  logic [N_RD-1:0][BW-1:0] rd_bank;
  logic                    coll_now, coll_q;

  actmem_xbar #(.BANKS(BANKS), .BANK_DEPTH(BANK_DEPTH), .DW(DW)) u_xbar (
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .b_re_o    (b_re),
    .b_raddr_o (b_raddr),
    .b_we_o    (b_we),
    .b_waddr_o (b_waddr),
    .b_wdata_o (b_wdata),
    .rd_gnt_o  (rd_gnt),
    .rd_bank_o (rd_bank),
    .coll_o    (coll_now)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    actmem_bank #(.DW(DW), .DEPTH(BANK_DEPTH)) u_bank (
      .clk_i   (clk_i),
      .we_i    (b_we[b]),
      .waddr_i (b_waddr[b]),
      .wdata_i (b_wdata[b]),
      .re_i    (b_re[b]),
      .raddr_i (b_raddr[b]),
      .rdata_o (b_rdata[b])
    );
  end

  actmem_rdret #(.BANKS(BANKS), .DW(DW), .BW(BW)) u_ret (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_gnt_i     (rd_gnt),
    .rd_bank_i    (rd_bank),
    .bank_rdata_i (b_rdata),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o)
  );

  // sticky until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coll_q <= 1'b0;
    else         coll_q <= coll_q | coll_now;
  end

  assign collision_o = coll_q;
endmodule

// File: rtl/actmem_chk.sv
module actmem_chk import actmem_pkg::*; #(
  parameter  int unsigned BANKS      = 3,
  parameter  int unsigned BANK_DEPTH = 256,
  parameter  int unsigned DW         = 64,
  localparam int unsigned OW         = $clog2(BANK_DEPTH),
  localparam int unsigned AW         = $clog2(BANKS*BANK_DEPTH)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_RD-1:0]         rd_en_i,
  input logic [N_RD-1:0][AW-1:0] rd_addr_i,
  input logic [N_RD-1:0]         rd_valid_o,
  input logic [N_RD-1:0][DW-1:0] rd_data_o,
  input logic [N_WR-1:0]         wr_en_i,
  input logic [N_WR-1:0][AW-1:0] wr_addr_i,
  input logic                    collision_o
);
  localparam logic [AW:0] LIMIT = (AW+1)'(BANKS*BANK_DEPTH);

  function automatic logic ok(input logic [AW-1:0] a);
    return {1'b0, a} < LIMIT;
  endfunction

  logic rd01_same, wr_same;
  assign rd01_same = rd_en_i[0] && rd_en_i[1] && ok(rd_addr_i[0]) && ok(rd_addr_i[1])
                     && (rd_addr_i[0][AW-1:OW] == rd_addr_i[1][AW-1:OW]);
  assign wr_same   = wr_en_i[0] && wr_en_i[1] && ok(wr_addr_i[0]) && ok(wr_addr_i[1])
                     && (wr_addr_i[0][AW-1:OW] == wr_addr_i[1][AW-1:OW]);

  for (genvar p = 0; p < N_RD; p++) begin : g_port
    AST_VALID_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o[p] |-> $past(rd_en_i[p] && ok(rd_addr_i[p]))); // R3
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_valid_o[p] |-> rd_data_o[p] == '0); // R3
    AST_OOR_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i[p] && !ok(rd_addr_i[p])) |=> !rd_valid_o[p]); // R8
  end

  AST_PORT0_ALWAYS_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i[0] && ok(rd_addr_i[0])) |=> rd_valid_o[0]); // R5
  AST_RD_LOSER_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd01_same |=> (!rd_valid_o[1] && collision_o)); // R5
  AST_WR_CLASH_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_same |=> collision_o); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |=> collision_o); // R7
endmodule

bind actmem_top actmem_chk #(.BANKS(BANKS), .BANK_DEPTH(BANK_DEPTH), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_en_i     (rd_en_i),
  .rd_addr_i   (rd_addr_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .collision_o (collision_o)
);

// File: tb/actmem_top_tb_top.sv
module actmem_top_tb_top;
  localparam int ELEM_W = 8;
  localparam int LANES  = 8;
  localparam int BANKS  = 3;
  localparam int DEPTH  = 64;
  localparam int DW     = ELEM_W * LANES;
  localparam int AW     = $clog2(BANKS*DEPTH);
  localparam int TOTAL  = BANKS * DEPTH;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0]         rd_en_i;
  logic [2:0][AW-1:0] rd_addr_i;
  logic [2:0]         rd_valid_o;
  logic [2:0][DW-1:0] rd_data_o;
  logic [1:0]         wr_en_i;
  logic [1:0][AW-1:0] wr_addr_i;
  logic [1:0][DW-1:0] wr_data_i;
  logic               collision_o;

  always #2.5 clk_i = ~clk_i;

  actmem_top #(.ELEM_W(ELEM_W), .LANES(LANES), .BANKS(BANKS), .BANK_DEPTH(DEPTH)) dut_i (
    .clk_i, .rst_ni, .rd_en_i, .rd_addr_i, .rd_valid_o, .rd_data_o,
    .wr_en_i, .wr_addr_i, .wr_data_i, .collision_o
  );

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] mdl [TOTAL];
  logic          exp_vld [3];
  logic [DW-1:0] exp_dat [3];
  logic          exp_coll = 1'b0;

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    rd_en_i = '0; rd_addr_i = '0; wr_en_i = '0; wr_addr_i = '0; wr_data_i = '0;
  endtask

  task automatic set_rd(input int p, input int a);
    rd_en_i[p] = 1'b1; rd_addr_i[p] = AW'(a);
  endtask

  task automatic set_wr(input int w, input int a, input logic [DW-1:0] d);
    wr_en_i[w] = 1'b1; wr_addr_i[w] = AW'(a); wr_data_i[w] = d;
  endtask

  // behavioural prediction from the requirements
  task automatic predict();
    bit rbusy [BANKS];
    bit wbusy [BANKS];
    int a;
    for (int b = 0; b < BANKS; b++) begin rbusy[b] = 0; wbusy[b] = 0; end
    for (int p = 0; p < 3; p++) begin
      exp_vld[p] = 1'b0; exp_dat[p] = '0;
      a = int'(rd_addr_i[p]);
      if (rd_en_i[p] && a < TOTAL) begin
        if (rbusy[a/DEPTH]) exp_coll = 1'b1;
        else begin rbusy[a/DEPTH] = 1; exp_vld[p] = 1'b1; exp_dat[p] = mdl[a]; end
      end
    end
    for (int w = 0; w < 2; w++) begin
      a = int'(wr_addr_i[w]);
      if (wr_en_i[w] && a < TOTAL) begin
        if (wbusy[a/DEPTH]) exp_coll = 1'b1;
        else begin wbusy[a/DEPTH] = 1; mdl[a] = wr_data_i[w]; end
      end
    end
  endtask

  task automatic compare(input string tag);
    for (int p = 0; p < 3; p++) begin
      chk({tag, " R3"}, $sformatf("valid port %0d", p), DW'(rd_valid_o[p]), DW'(exp_vld[p]));
      chk({tag, " R10"}, $sformatf("data port %0d", p), rd_data_o[p], exp_dat[p]);
    end
    chk({tag, " R7"}, "collision", DW'(collision_o), DW'(exp_coll));
  endtask

  task automatic cycle(input string tag);
    predict();
    @(posedge clk_i);
    @(negedge clk_i);
    compare(tag);
    clear_in();
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [DW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*ELEM_W +: ELEM_W] = ELEM_W'(a*7 + i*31 + salt);
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    clear_in();
    #1;
    exp_coll = 1'b0;
    chk("R9", "valid in reset", DW'(rd_valid_o), '0);
    chk("R9", "collision in reset", DW'(collision_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9", "valid after reset", DW'(rd_valid_o), '0);
    chk("R9", "collision after reset", DW'(collision_o), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    clear_in();
    for (int i = 0; i < 3; i++) begin exp_vld[i] = 1'b0; exp_dat[i] = '0; end
    repeat (3) @(negedge clk_i);
    chk("R9", "valid in reset", DW'(rd_valid_o), '0);
    chk("R9", "collision in reset", DW'(collision_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // fill every word: two writers in different banks each cycle
    for (int a = 0; a < DEPTH; a++) begin
      set_wr(0, a, pat(a, 1));
      set_wr(1, a + DEPTH, pat(a + DEPTH, 1));
      cycle("R1");
    end
    for (int a = 2*DEPTH; a < TOTAL; a++) begin
      set_wr(1, a, pat(a, 1));
      cycle("R1");
    end

    // R1: five concurrent accesses to distinct banks
    for (int k = 0; k < 8; k++) begin
      set_rd(0, k); set_rd(1, DEPTH + 3*k); set_rd(2, 2*DEPTH + 5*k);
      set_wr(0, 2*DEPTH + 10 + k, pat(k, 2)); set_wr(1, 20 + k, pat(k, 3));
      cycle("R1");
    end

    // R2: neighbouring addresses across the bank 0 / bank 1 boundary
    set_rd(0, DEPTH - 1); set_rd(1, DEPTH); set_rd(2, 2*DEPTH - 1);
    cycle("R2");
    set_rd(0, 2*DEPTH); set_rd(2, 2*DEPTH - 1);
    cycle("R2");

    // R4: read-before-write on the same address, then new data
    set_rd(0, 5); set_wr(0, 5, pat(5, 9));
    set_rd(1, DEPTH + 7); set_wr(1, DEPTH + 7, pat(7, 9));
    cycle("R4");
    set_rd(0, 5); set_rd(1, DEPTH + 7);
    cycle("R4");

    // R8: out-of-range requests are ignored and never collide
    set_rd(1, 200); set_rd(2, 250); set_wr(0, 200, pat(0, 4)); set_wr(1, 255, pat(1, 4));
    cycle("R8");
    set_rd(0, 0); set_rd(2, TOTAL - 1);
    cycle("R8");

    // R5: ports 0 and 2 in bank 1, port 1 in bank 0
    set_rd(0, DEPTH + 1); set_rd(1, 2); set_rd(2, DEPTH + 9);
    cycle("R5");
    set_rd(1, 2*DEPTH + 3); set_rd(2, 2*DEPTH + 4);
    cycle("R5");

    // R6: both writers in bank 2; only port 0 lands
    set_wr(0, 2*DEPTH + 30, pat(30, 5)); set_wr(1, 2*DEPTH + 31, pat(31, 5));
    cycle("R6");
    set_rd(0, 2*DEPTH + 30);
    cycle("R6");
    set_rd(0, 2*DEPTH + 31);
    cycle("R6");

    // R7: flag holds with idle traffic
    repeat (4) cycle("R7");

    do_reset();

    // R9: contents survive reset
    set_rd(0, 5); set_rd(1, DEPTH + 7); set_rd(2, 2*DEPTH + 31);
    cycle("R9");

    // mixed random traffic, including out-of-range addresses
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < 3; p++) if ($urandom_range(0, 3) != 0) set_rd(p, $urandom_range(0, 255));
      for (int w = 0; w < 2; w++)
        if ($urandom_range(0, 2) != 0) set_wr(w, $urandom_range(0, 255), {$urandom, $urandom});
      cycle("R1");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule